// File: doc/BRIEF.md
# Write-Synchronized Peripheral Control Register

This block is the control register of a peripheral whose working logic runs on a core clock, while the register sits on the bus clock. Software reaches it through 32-bit word accesses. It holds an on/off bit, a self-clearing reset request and a clock-source select. The on/off value and the reset request travel into the core clock domain through toggle handshakes. A second, read-only word shows a busy flag for each crossing that has not finished.

The clock-select bit drives its output straight from the bus-side flop and does not pass through a synchronizer. A write-lock input refuses every write and reports a one-cycle error. Any new control write made while a crossing is still busy is stalled through the ready signal until the crossing completes. A reset request overrides every other field of the write that carries it. When the core domain has acted on the request, the whole register returns to its power-up value.

Top module: `wsync_ctrl`

## Requirements
- R1: After reset the control word (word address 0) and the busy word (word address 1) read 0, clk_sel_o and core_enable_o are 0, and ready_o is 1.
- R2: Only a write with all byte strobes set (be_i = 4'hF) to word address 0 takes effect. Partial-strobe writes and writes to word address 1 change nothing.
- R3: Control word layout: bit 0 reset request, bit 1 enable, bit 4 clock select. All other bits always read 0.
- R4: Every accepted control write without the reset bit loads enable at once, so the next read shows it. The same write sets busy bit 1 (word address 1) on the following cycle. Bit 1 clears only after core_enable_o has taken the new value.
- R5: clk_sel_o follows the clock-select bit from the cycle after the write, with no synchronizer (0 = fast generic clock, 1 = low-power 32 kHz clock).
- R6: A write to clock select is ignored while enable reads 1.
- R7: A write with bit 0 set discards its other fields and sets bit 0 and busy bit 0. Both stay 1 until the core domain has seen the request, and both then clear on the same cycle. At that point every field is 0, core_enable_o is 0, and core_swrst_o has pulsed once in the core domain.
- R8: While wprot_i is high, a write changes nothing and err_o is high in that access cycle.
- R9: A full-word control write presented while either busy flag is set holds ready_o low until both flags clear, and then takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| core_clk_i | input | 1 | Core clock |
| core_rst_ni | input | 1 | Core-domain asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address: 0 control, 1 busy |
| be_i | input | 4 | Byte strobes |
| wdata_i | input | 32 | Write data |
| wprot_i | input | 1 | Write lock |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| ready_o | output | 1 | Access completes on this edge |
| err_o | output | 1 | Locked-write error |
| clk_sel_o | output | 1 | Clock-source select |
| core_enable_o | output | 1 | Enable in the core domain |
| core_swrst_o | output | 1 | One-core-cycle reset pulse |

## Verification
The enable handover is tested three ways. First, enable is turned on from idle together with a clock select. Second, enable is rewritten while already on, which shows that the clock-select lock holds. Third, two writes are issued back to back, which must produce a stall rather than a lost value. Writes with partial strobes, writes to the read-only address and locked writes are each followed by a readback, so a dropped write can be told apart from one that was applied. Reset requests are issued both from idle and with a write queued behind them. This shows whether the other fields are discarded, whether the reset bit and its busy flag fall together, and whether the queued write lands after the register has been cleared.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  localparam int unsigned NUM_XFER  = 2;
  localparam int unsigned SW_IDX    = 0;
  localparam int unsigned EN_IDX    = 1;
  localparam int unsigned SWRST_BIT = 0;
  localparam int unsigned ENABLE_BIT = 1;
  localparam int unsigned CKSEL_BIT = 4;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned BUSY_ADDR = 1;
endpackage

// File: rtl/wsync_flop_chain.sv
module wsync_flop_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/wsync_handshake.sv
module wsync_handshake #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_clk_i,
  input  logic core_rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic core_evt_o
);
  logic req_q, busy_q, ack_s;
  logic req_s, ack_q;

  // bus side: toggle per request, busy until the echo returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (start_i) req_q <= ~req_q;
      if (start_i)     busy_q <= 1'b1;
      else if (done_o) busy_q <= 1'b0;
    end
  end

  assign done_o = busy_q & (ack_s == req_q);
  assign busy_o = busy_q;

  wsync_flop_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(core_clk_i), .rst_ni(core_rst_ni), .d_i(req_q), .q_o(req_s)
  );

  always_ff @(posedge core_clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) ack_q <= 1'b0;
    else              ack_q <= req_s;
  end

  assign core_evt_o = req_s ^ ack_q;

  wsync_flop_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s)
  );
endmodule

// File: rtl/wsync_ctrl.sv
module wsync_ctrl
  import wsync_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_clk_i,
  input  logic              core_rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wprot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              clk_sel_o,
  output logic              core_enable_o,
  output logic              core_swrst_o
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic enable_q, cksel_q, swrst_q, core_en_q;
  logic wr_ctrl, busy_any, accept, do_rst, en_start;
  logic [NUM_XFER-1:0] hs_start, hs_busy, hs_done, hs_evt;

  assign wr_ctrl  = req_i & we_i & ~wprot_i & (&be_i) & (addr_i == ADDR_W'(CTRL_ADDR));
  assign busy_any = |hs_busy;
  assign accept   = wr_ctrl & ~busy_any;
  assign do_rst   = accept & wdata_i[SWRST_BIT];
  assign en_start = accept & ~wdata_i[SWRST_BIT];
  assign ready_o  = ~(wr_ctrl & busy_any);
  assign err_o    = req_i & we_i & wprot_i;

  assign hs_start[SW_IDX] = do_rst;
  assign hs_start[EN_IDX] = en_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      cksel_q  <= 1'b0;
      swrst_q  <= 1'b0;
    end else if (hs_done[SW_IDX]) begin
      enable_q <= 1'b0;
      cksel_q  <= 1'b0;
      swrst_q  <= 1'b0;
    end else if (do_rst) begin
      swrst_q <= 1'b1;
    end else if (en_start) begin
      enable_q <= wdata_i[ENABLE_BIT];
      if (!enable_q) cksel_q <= wdata_i[CKSEL_BIT];
    end
  end

  for (genvar g = 0; g < NUM_XFER; g++) begin : g_xfer
    wsync_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .core_clk_i (core_clk_i),
      .core_rst_ni(core_rst_ni),
      .start_i    (hs_start[g]),
      .busy_o     (hs_busy[g]),
      .done_o     (hs_done[g]),
      .core_evt_o (hs_evt[g])
    );
  end

  // enable_q is held stable while its crossing is busy
  always_ff @(posedge core_clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni)          core_en_q <= 1'b0;
    else if (hs_evt[SW_IDX])   core_en_q <= 1'b0;
    else if (hs_evt[EN_IDX])   core_en_q <= enable_q;
  end

  assign core_enable_o = core_en_q;
  assign core_swrst_o  = hs_evt[SW_IDX];
  assign clk_sel_o     = cksel_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(CTRL_ADDR): begin
        rdata_o[SWRST_BIT]  = swrst_q;
        rdata_o[ENABLE_BIT] = enable_q;
        rdata_o[CKSEL_BIT]  = cksel_q;
      end
      ADDR_W'(BUSY_ADDR): rdata_o[NUM_XFER-1:0] = hs_busy;
      default: ;
    endcase
  end
endmodule

// File: rtl/wsync_ctrl_chk.sv
module wsync_ctrl_chk
  import wsync_pkg::*;
#(
  parameter int unsigned BE_W = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic                wprot_i,
  input logic [BE_W-1:0]     be_i,
  input logic                ready_o,
  input logic                core_enable_o,
  input logic                enable_q,
  input logic                cksel_q,
  input logic                swrst_q,
  input logic [NUM_XFER-1:0] hs_start,
  input logic [NUM_XFER-1:0] hs_busy,
  input logic [NUM_XFER-1:0] hs_done
);
  AST_RST_BIT_TRACKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q == hs_busy[SW_IDX]); // R7

  AST_CORE_EN_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hs_busy) |-> core_enable_o == enable_q); // R4

  AST_STALL_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> |hs_busy); // R9

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hs_start & hs_busy)) == 1'b0); // R9

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wprot_i && !hs_done[SW_IDX]) |=> $stable({enable_q, cksel_q, swrst_q})); // R8

  AST_PARTIAL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !(&be_i) && !hs_done[SW_IDX]) |=> $stable({enable_q, cksel_q, swrst_q})); // R2

  AST_CKSEL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_q && !hs_done[SW_IDX]) |=> $stable(cksel_q)); // R6
endmodule

bind wsync_ctrl wsync_ctrl_chk #(.BE_W(BE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .wprot_i      (wprot_i),
  .be_i         (be_i),
  .ready_o      (ready_o),
  .core_enable_o(core_enable_o),
  .enable_q     (enable_q),
  .cksel_q      (cksel_q),
  .swrst_q      (swrst_q),
  .hs_start     (hs_start),
  .hs_busy      (hs_busy),
  .hs_done      (hs_done)
);

// File: tb/wsync_ctrl_tb_top.sv
`timescale 1ns/1ps
module wsync_ctrl_tb_top;
  logic clk_i = 1'b0, core_clk_i = 1'b0;
  logic rst_ni = 1'b0, core_rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wprot_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [3:0] be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic ready_o, err_o, clk_sel_o, core_enable_o, core_swrst_o;

  always #5  clk_i = ~clk_i;
  always #17 core_clk_i = ~core_clk_i;

  wsync_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_clk_i(core_clk_i), .core_rst_ni(core_rst_ni),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
    .wprot_i(wprot_i), .rdata_o(rdata_o), .ready_o(ready_o), .err_o(err_o),
    .clk_sel_o(clk_sel_o), .core_enable_o(core_enable_o), .core_swrst_o(core_swrst_o)
  );

  int n_vec = 0, n_err = 0, sw_pulses = 0;
  bit mon_on = 1'b0;
  bit m_en = 0, m_cksel = 0, m_swrst = 0, m_en_pend = 0, m_sw_pend = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_exp();
    return {27'b0, m_cksel, 2'b00, m_en, m_swrst};
  endfunction

  task automatic complete_pend();
    if (m_sw_pend) begin
      m_en = 0; m_cksel = 0; m_swrst = 0;
    end
    m_sw_pend = 0; m_en_pend = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d,
                           input bit prot, output int stalls);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; be_i = be; wdata_i = d; wprot_i = prot;
    stalls = 0;
    #1;
    while (!ready_o) begin
      stalls++;
      @(negedge clk_i); #1;
    end
    chk(err_o == prot, "R8 err_o", {31'b0, err_o}, {31'b0, prot});
    @(posedge clk_i);
    if (stalls > 0) complete_pend();
    if (!prot && be == 4'hF && a == 2'd0) begin
      if (d[0]) begin
        m_swrst = 1; m_sw_pend = 1;
      end else begin
        if (!m_en) m_cksel = d[4];
        m_en = d[1]; m_en_pend = 1;
      end
    end
    @(negedge clk_i);
    req_i = 0; we_i = 0; wprot_i = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1;
    d = rdata_o;
    req_i = 0;
  endtask

  task automatic wait_idle(input string rq);
    logic [31:0] b;
    b = '1;
    for (int i = 0; i < 100 && b != 0; i++) bus_read(2'd1, b);
    chk(b == 0, {rq, " busy clears"}, b, 0);
    complete_pend();
    chk(core_enable_o == m_en, {rq, " core enable"}, {31'b0, core_enable_o}, {31'b0, m_en});
  endtask

  always @(posedge core_clk_i) if (core_swrst_o) sw_pulses++;

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (mon_on && !m_sw_pend)
      chk(clk_sel_o == m_cksel, "R5 clk_sel_o", {31'b0, clk_sel_o}, {31'b0, m_cksel});
  end

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired R9 act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int st, p0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1; core_rst_ni = 1;
    mon_on = 1;

    // R1
    bus_read(2'd0, r); chk(r == 0, "R1 ctrl reset", r, 0);
    bus_read(2'd1, r); chk(r == 0, "R1 busy reset", r, 0);
    chk(core_enable_o == 0 && ready_o == 1 && err_o == 0, "R1 outputs",
        {29'b0, core_enable_o, ready_o, err_o}, 32'h2);

    // R4 R3: enable on with clock select
    bus_write(2'd0, 4'hF, 32'h12, 0, st);
    bus_read(2'd0, r); chk(r == ctrl_exp(), "R4 enable readback", r, ctrl_exp());
    bus_read(2'd1, r); chk(r == 32'h2, "R4 enable busy", r, 32'h2);
    wait_idle("R4");

    // R6: clock select locked while enabled
    bus_write(2'd0, 4'hF, 32'h02, 0, st);
    bus_read(2'd0, r); chk(r == 32'h12, "R6 cksel locked", r, 32'h12);
    wait_idle("R6");

    // R9: back-to-back writes stall
    bus_write(2'd0, 4'hF, 32'h00, 0, st);
    bus_write(2'd0, 4'hF, 32'h10, 0, st);
    chk(st > 0, "R9 stall cycles", st, 1);
    wait_idle("R9");
    bus_read(2'd0, r); chk(r == 32'h10, "R9 held write applied", r, 32'h10);

    // R2: partial strobes and read-only address
    bus_write(2'd0, 4'h3, 32'h02, 0, st);
    bus_read(2'd0, r); chk(r == 32'h10, "R2 partial write", r, 32'h10);
    bus_write(2'd1, 4'hF, 32'h12, 0, st);
    bus_read(2'd0, r); chk(r == 32'h10, "R2 busy addr write", r, 32'h10);
    bus_read(2'd1, r); chk(r == 0, "R2 no busy", r, 0);

    // R8: locked write
    bus_write(2'd0, 4'hF, 32'h02, 1, st);
    bus_read(2'd0, r); chk(r == 32'h10, "R8 locked write", r, 32'h10);
    bus_read(2'd1, r); chk(r == 0, "R8 no busy", r, 0);

    // R3: reserved bits
    bus_write(2'd0, 4'hF, 32'hFFFF_FFEE, 0, st);
    bus_read(2'd0, r); chk(r == 32'h02, "R3 reserved read 0", r, 32'h02);
    wait_idle("R3");

    // R7: reset request discards other fields
    p0 = sw_pulses;
    bus_write(2'd0, 4'hF, 32'h11, 0, st);
    bus_read(2'd0, r); chk(r == 32'h03, "R7 reset ongoing", r, 32'h03);
    bus_read(2'd1, r); chk(r == 32'h1, "R7 reset busy", r, 32'h1);
    wait_idle("R7");
    bus_read(2'd0, r); chk(r == 0, "R7 register cleared", r, 0);
    chk(sw_pulses == p0 + 1, "R7 core reset pulse", sw_pulses, p0 + 1);

    // R9 R7: write queued behind reset lands after clear
    bus_write(2'd0, 4'hF, 32'h01, 0, st);
    bus_write(2'd0, 4'hF, 32'h12, 0, st);
    chk(st > 0, "R9 stall behind reset", st, 1);
    wait_idle("R9 after reset");
    bus_read(2'd0, r); chk(r == 32'h12, "R7 write after reset", r, 32'h12);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule